// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block is the execute stage of an 8-bit accumulator processor that uses 14-bit instruction words. It takes one instruction word, the working register W and the register-file operand selected by the instruction's 7-bit address field. From these it computes a result and a destination: W, the register file, or no write at all. It also computes new carry, half-carry and zero flags and a request to skip the next instruction. The block covers arithmetic, logic, rotates, nibble swap, single-bit set, clear and test, and operations with an 8-bit literal.

The caller supplies the current flags with each instruction, and the block returns the complete flag set after that instruction. A flag that an opcode does not affect is passed through unchanged. All outputs are registered, so the result of an instruction issued with `valid_i` high appears one clock later. Fetch, program counter sequencing, register storage and ports belong to neighbouring blocks. Encodings that this stage does not execute, including flow control, behave as no-operations.

Top module: `acc_execute_unit`

## Requirements
- R1: For register-operand instructions (bits 13:8 opcode, bit 7 destination, bits 6:0 register address), destination bit 0 writes the result to W (`wr_w_o`) and 1 writes it to the register (`wr_reg_o`, address on `reg_addr_o`). The two write strobes are never high together.
- R2: Opcode 011011 produces W + R. C is the carry out of bit 7, HC is the carry out of bit 3, and Z is set when the result is zero.
- R3: Opcode 011100 produces R + ~W + 1. C and HC are the carries out of bits 7 and 3 of that sum, so C=1 means no borrow. Z is set on a zero result.
- R4: Register AND (010010), OR (010011), XOR (010100) and complement (011111) update only Z. Register move (011000) also updates only Z.
- R5: Increment (011001) and decrement (011101) update only Z. The skip forms (011010 increment, 011110 decrement) keep all flags and raise `skip_o` when the result is zero.
- R6: Rotate left (010101) moves C into bit 0 and bit 7 into C. Rotate right (010110) moves C into bit 7 and bit 0 into C. Only C changes.
- R7: Swap (010111) exchanges the two nibbles of R and keeps all flags.
- R8: Bit instructions have a 4-bit prefix in bits 13:10 and a bit index in bits 9:7. Prefix 0000 clears the bit and 0010 sets it, both writing the register. Prefix 0001 skips if the bit is 0 and prefix 0011 skips if it is 1; neither writes. No bit instruction changes a flag.
- R9: The literal forms take the immediate in bits 7:0 and always write W. Load (111010) keeps the flags. AND (110100), OR (110101) and XOR (110110) update Z.
- R10: 010000 with bit 7 = 1 clears W, and 010001 with bit 7 = 0 clears the register; both set Z. 010001 with bit 7 = 1 stores W to the register and keeps the flags.
- R11: Every other encoding makes no write, raises no skip and returns the input flags unchanged.
- R12: Outputs are registered, with one cycle of latency. After reset, and in any cycle after `valid_i` was low, `valid_o`, both write strobes and `skip_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 14 | Instruction word |
| w_i | input | 8 | Working register W |
| reg_i | input | 8 | Register-file operand |
| c_i | input | 1 | Current carry flag |
| hc_i | input | 1 | Current half-carry flag |
| z_i | input | 1 | Current zero flag |
| valid_o | output | 1 | Registered result valid |
| result_o | output | 8 | Result value |
| wr_w_o | output | 1 | Write result to W |
| wr_reg_o | output | 1 | Write result to register |
| reg_addr_o | output | 7 | Register address for the write |
| c_o | output | 1 | Updated carry |
| hc_o | output | 1 | Updated half-carry |
| z_o | output | 1 | Updated zero |
| skip_o | output | 1 | Skip next instruction |

## Verification
The bench builds the block with its default 8-bit data and 7-bit address widths. At these widths every operand value is within reach of a sweep.
- Add and subtract are swept over all 256 register values against a dense set of W values. This covers every carry and half-carry boundary, including subtraction of zero.
- The other register operations run over every register value, four W patterns, both destinations and changing input flags.
- The bit, literal and unrecognised-opcode sweeps walk every opcode prefix and a spread of low bytes.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [4:0] {
    OP_NOP, OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM,
    OP_INC, OP_DEC, OP_INCSZ, OP_DECSZ, OP_RLC, OP_RRC, OP_SWAP,
    OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS, OP_LDI, OP_ANDI, OP_IORI,
    OP_XORI, OP_CLRW, OP_CLRR, OP_STW
  } exec_op_e;

  typedef struct packed {
    exec_op_e op;
    logic     dst_reg;
  } exec_dec_t;

  typedef struct packed {
    logic c;
    logic hc;
    logic z;
  } exec_flags_t;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
(
  input  logic       valid,
  input  logic [5:0] opc,
  input  logic       tbit,
  output exec_dec_t  dec
);
  always_comb begin
    dec.op      = OP_NOP;
    dec.dst_reg = tbit;
    if (valid) begin
      casez (opc)
        6'b0000??: begin dec.op = OP_BCLR; dec.dst_reg = 1'b1; end
        6'b0010??: begin dec.op = OP_BSET; dec.dst_reg = 1'b1; end
        6'b0001??: dec.op = OP_BTSC;
        6'b0011??: dec.op = OP_BTSS;
        6'b010000: begin
          dec.op      = tbit ? OP_CLRW : OP_NOP;
          dec.dst_reg = 1'b0;
        end
        6'b010001: begin
          dec.op      = tbit ? OP_STW : OP_CLRR;
          dec.dst_reg = 1'b1;
        end
        6'b010010: dec.op = OP_AND;
        6'b010011: dec.op = OP_IOR;
        6'b010100: dec.op = OP_XOR;
        6'b010101: dec.op = OP_RLC;
        6'b010110: dec.op = OP_RRC;
        6'b010111: dec.op = OP_SWAP;
        6'b011000: dec.op = OP_MOV;
        6'b011001: dec.op = OP_INC;
        6'b011010: dec.op = OP_INCSZ;
        6'b011011: dec.op = OP_ADD;
        6'b011100: dec.op = OP_SUB;
        6'b011101: dec.op = OP_DEC;
        6'b011110: dec.op = OP_DECSZ;
        6'b011111: dec.op = OP_COM;
        6'b111010: begin dec.op = OP_LDI;  dec.dst_reg = 1'b0; end
        6'b110100: begin dec.op = OP_ANDI; dec.dst_reg = 1'b0; end
        6'b110101: begin dec.op = OP_IORI; dec.dst_reg = 1'b0; end
        6'b110110: begin dec.op = OP_XORI; dec.dst_reg = 1'b0; end
        default:   dec.op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int NIB_W = DATA_W / 2
) (
  input  exec_op_e          op,
  input  logic [DATA_W-1:0] w,
  input  logic [DATA_W-1:0] r,
  input  logic [DATA_W-1:0] imm,
  input  logic [BIT_W-1:0]  bidx,
  input  exec_flags_t       fin,
  output logic [DATA_W-1:0] res,
  output exec_flags_t       fout,
  output logic              wr,
  output logic              skip
);
  logic [DATA_W:0]   add_sum, sub_sum;
  logic [NIB_W:0]    add_lo, sub_lo;
  logic [DATA_W-1:0] inc_v, dec_v, mask;

  always_comb begin
    add_sum = {1'b0, r} + {1'b0, w};
    sub_sum = {1'b0, r} + {1'b0, ~w} + {{DATA_W{1'b0}}, 1'b1};
    add_lo  = {1'b0, r[NIB_W-1:0]} + {1'b0, w[NIB_W-1:0]};
    sub_lo  = {1'b0, r[NIB_W-1:0]} + {1'b0, ~w[NIB_W-1:0]} + {{NIB_W{1'b0}}, 1'b1};
    inc_v   = r + 1'b1;
    dec_v   = r - 1'b1;
    mask    = {{(DATA_W-1){1'b0}}, 1'b1} << bidx;
  end

  always_comb begin
    res  = '0;
    fout = fin;
    wr   = 1'b1;
    skip = 1'b0;
    unique case (op)
      OP_MOV:   begin res = r;     fout.z = (res == '0); end
      OP_ADD:   begin
        res = add_sum[DATA_W-1:0];
        fout.c = add_sum[DATA_W]; fout.hc = add_lo[NIB_W]; fout.z = (res == '0);
      end
      OP_SUB:   begin
        res = sub_sum[DATA_W-1:0];
        fout.c = sub_sum[DATA_W]; fout.hc = sub_lo[NIB_W]; fout.z = (res == '0);
      end
      OP_AND:   begin res = r & w;   fout.z = (res == '0); end
      OP_IOR:   begin res = r | w;   fout.z = (res == '0); end
      OP_XOR:   begin res = r ^ w;   fout.z = (res == '0); end
      OP_COM:   begin res = ~r;      fout.z = (res == '0); end
      OP_INC:   begin res = inc_v;   fout.z = (res == '0); end
      OP_DEC:   begin res = dec_v;   fout.z = (res == '0); end
      OP_INCSZ: begin res = inc_v;   skip = (inc_v == '0); end
      OP_DECSZ: begin res = dec_v;   skip = (dec_v == '0); end
      OP_RLC:   begin res = {r[DATA_W-2:0], fin.c}; fout.c = r[DATA_W-1]; end
      OP_RRC:   begin res = {fin.c, r[DATA_W-1:1]}; fout.c = r[0]; end
      OP_SWAP:  res = {r[NIB_W-1:0], r[DATA_W-1:NIB_W]};
      OP_BCLR:  res = r & ~mask;
      OP_BSET:  res = r | mask;
      OP_BTSC:  begin wr = 1'b0; skip = ((r & mask) == '0); end
      OP_BTSS:  begin wr = 1'b0; skip = ((r & mask) != '0); end
      OP_LDI:   res = imm;
      OP_ANDI:  begin res = imm & w; fout.z = (res == '0); end
      OP_IORI:  begin res = imm | w; fout.z = (res == '0); end
      OP_XORI:  begin res = imm ^ w; fout.z = (res == '0); end
      OP_CLRW, OP_CLRR: begin res = '0; fout.z = 1'b1; end
      OP_STW:   res = w;
      default:  wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_execute_unit.sv
module acc_execute_unit
  import exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int INSTR_W = ADDR_W + 7,
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  w_i,
  input  logic [DATA_W-1:0]  reg_i,
  input  logic               c_i,
  input  logic               hc_i,
  input  logic               z_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_w_o,
  output logic               wr_reg_o,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic               c_o,
  output logic               hc_o,
  output logic               z_o,
  output logic               skip_o
);
  exec_dec_t         dec;
  exec_flags_t       fin, fout;
  logic [DATA_W-1:0] res;
  logic              wr, skip;

  assign fin = '{c: c_i, hc: hc_i, z: z_i};

  exec_decode u_dec (
    .valid (valid_i),
    .opc   (instr_i[INSTR_W-1 -: 6]),
    .tbit  (instr_i[ADDR_W]),
    .dec   (dec)
  );

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (dec.op),
    .w    (w_i),
    .r    (reg_i),
    .imm  (instr_i[DATA_W-1:0]),
    .bidx (instr_i[ADDR_W +: BIT_W]),
    .fin  (fin),
    .res  (res),
    .fout (fout),
    .wr   (wr),
    .skip (skip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      wr_w_o     <= 1'b0;
      wr_reg_o   <= 1'b0;
      reg_addr_o <= '0;
      c_o        <= 1'b0;
      hc_o       <= 1'b0;
      z_o        <= 1'b0;
      skip_o     <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      result_o   <= res;
      wr_w_o     <= wr & ~dec.dst_reg;
      wr_reg_o   <= wr & dec.dst_reg;
      reg_addr_o <= instr_i[ADDR_W-1:0];
      c_o        <= fout.c;
      hc_o       <= fout.hc;
      z_o        <= fout.z;
      skip_o     <= skip;
    end
  end
endmodule

// File: rtl/acc_execute_chk.sv
module acc_execute_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int INSTR_W = ADDR_W + 7,
  localparam int NIB_W   = DATA_W / 2
) (
  input logic               clk,
  input logic               rst,
  input logic               valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  reg_i,
  input logic               c_i,
  input logic               hc_i,
  input logic               z_i,
  input logic               valid_o,
  input logic [DATA_W-1:0]  result_o,
  input logic               wr_w_o,
  input logic               wr_reg_o,
  input logic               c_o,
  input logic               hc_o,
  input logic               z_o,
  input logic               skip_o
);
  assert_one_dest_R1: assert property (@(posedge clk) disable iff (rst)
    !(wr_w_o && wr_reg_o));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (!wr_w_o && !wr_reg_o && !skip_o));

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  assert_skip_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> ({c_o, hc_o, z_o} == $past({c_i, hc_i, z_i})));

  assert_add_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[INSTR_W-1 -: 6] == 6'b011011) |=> (z_o == (result_o == '0)));

  assert_swap_nibbles_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[INSTR_W-1 -: 6] == 6'b010111) |=>
      (result_o == {$past(reg_i[NIB_W-1:0]), $past(reg_i[DATA_W-1:NIB_W])}
       && {c_o, hc_o, z_o} == $past({c_i, hc_i, z_i})));
endmodule

bind acc_execute_unit acc_execute_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_i  (valid_i),
  .instr_i  (instr_i),
  .reg_i    (reg_i),
  .c_i      (c_i),
  .hc_i     (hc_i),
  .z_i      (z_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .wr_w_o   (wr_w_o),
  .wr_reg_o (wr_reg_o),
  .c_o      (c_o),
  .hc_o     (hc_o),
  .z_o      (z_o),
  .skip_o   (skip_o)
);

// File: tb/tb_acc_execute_unit.sv
module tb_acc_execute_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [13:0] instr_i = '0;
  logic [7:0]  w_i = '0, reg_i = '0;
  logic        c_i = 1'b0, hc_i = 1'b0, z_i = 1'b0;
  logic        valid_o, wr_w_o, wr_reg_o, c_o, hc_o, z_o, skip_o;
  logic [7:0]  result_o;
  logic [6:0]  reg_addr_o;

  int n_vec = 0, n_bad = 0;
  longint cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_execute_unit dut (.*);

  typedef struct {
    bit       ww, wr, c, hc, z, sk;
    bit [7:0] res;
  } exp_t;

  function automatic string req_of(input bit [13:0] ins);
    casez (ins[13:8])
      6'b00????:                         return "R8";
      6'b010000, 6'b010001:              return ins[7] || ins[13:8] == 6'b010001 ? "R10" : "R11";
      6'b011011:                         return "R2";
      6'b011100:                         return "R3";
      6'b010010, 6'b010011, 6'b010100,
      6'b011111, 6'b011000:              return "R4";
      6'b011001, 6'b011010, 6'b011101,
      6'b011110:                         return "R5";
      6'b010101, 6'b010110:              return "R6";
      6'b010111:                         return "R7";
      6'b111010, 6'b110100, 6'b110101,
      6'b110110:                         return "R9";
      default:                           return "R11";
    endcase
  endfunction

  function automatic exp_t model(input bit [13:0] ins, input bit [7:0] w, r,
                                 input bit c, hc, z);
    exp_t e;
    bit t = ins[7];
    bit [2:0] b = ins[9:7];
    bit [7:0] im = ins[7:0];
    int s;
    e = '{ww: 0, wr: 0, c: c, hc: hc, z: z, sk: 0, res: 0};
    casez (ins[13:8])
      6'b0000??: begin e.wr = 1; e.res = r; e.res[b] = 1'b0; end
      6'b0010??: begin e.wr = 1; e.res = r; e.res[b] = 1'b1; end
      6'b0001??: e.sk = (r[b] == 1'b0);
      6'b0011??: e.sk = (r[b] == 1'b1);
      6'b010000: if (t) begin e.ww = 1; e.res = 0; e.z = 1; end
      6'b010001: begin e.wr = 1; e.res = t ? w : 8'd0; if (!t) e.z = 1; end
      6'b111010: begin e.ww = 1; e.res = im; end
      6'b110100: begin e.ww = 1; e.res = im & w; e.z = (e.res == 0); end
      6'b110101: begin e.ww = 1; e.res = im | w; e.z = (e.res == 0); end
      6'b110110: begin e.ww = 1; e.res = im ^ w; e.z = (e.res == 0); end
      6'b01????: begin
        e.ww = !t; e.wr = t;
        case (ins[13:8])
          6'b011011: begin
            s = int'(w) + int'(r); e.res = s[7:0]; e.c = s > 255;
            e.hc = (int'(w % 16) + int'(r % 16)) > 15; e.z = (e.res == 0);
          end
          6'b011100: begin
            s = int'(r) - int'(w); e.res = s[7:0]; e.c = (r >= w);
            e.hc = (r % 16) >= (w % 16); e.z = (e.res == 0);
          end
          6'b010010: begin e.res = r & w; e.z = (e.res == 0); end
          6'b010011: begin e.res = r | w; e.z = (e.res == 0); end
          6'b010100: begin e.res = r ^ w; e.z = (e.res == 0); end
          6'b011111: begin e.res = 8'hFF - r; e.z = (e.res == 0); end
          6'b011000: begin e.res = r; e.z = (r == 0); end
          6'b011001: begin e.res = r + 8'd1; e.z = (r == 8'hFF); end
          6'b011101: begin e.res = r - 8'd1; e.z = (r == 8'h01); end
          6'b011010: begin e.res = r + 8'd1; e.sk = (r == 8'hFF); end
          6'b011110: begin e.res = r - 8'd1; e.sk = (r == 8'h01); end
          6'b010101: begin e.res = r * 2 + c; e.c = r >= 128; end
          6'b010110: begin e.res = r / 2 + (c ? 8'd128 : 8'd0); e.c = r % 2; end
          6'b010111: e.res = (r % 16) * 16 + r / 16;
          default:   begin e.ww = 0; e.wr = 0; end
        endcase
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic apply(input bit [13:0] ins, input bit [7:0] w, r, input bit [2:0] f);
    exp_t e = model(ins, w, r, f[2], f[1], f[0]);
    bit bad;
    valid_i = 1'b1; instr_i = ins; w_i = w; reg_i = r;
    {c_i, hc_i, z_i} = f;
    @(negedge clk);
    n_vec++;
    bad = (valid_o !== 1'b1) || (wr_w_o !== e.ww) || (wr_reg_o !== e.wr) ||
          (skip_o !== e.sk) || ({c_o, hc_o, z_o} !== {e.c, e.hc, e.z}) ||
          ((e.ww || e.wr) && result_o !== e.res) ||
          (e.wr && reg_addr_o !== ins[6:0]);
    if (bad) begin
      n_bad++;
      if (n_bad < 20)
        $display("FAIL %s instr=%b w=%h r=%h f=%b: got ww%0b wr%0b res=%h a=%h f=%b sk%0b, exp ww%0b wr%0b res=%h f=%b sk%0b",
                 req_of(ins), ins, w, r, f, wr_w_o, wr_reg_o, result_o, reg_addr_o,
                 {c_o, hc_o, z_o}, skip_o, e.ww, e.wr, e.res, {e.c, e.hc, e.z}, e.sk);
    end
  endtask

  task automatic check_idle(input string tag);
    n_vec++;
    if (valid_o !== 1'b0 || wr_w_o !== 1'b0 || wr_reg_o !== 1'b0 || skip_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s idle: got v%0b ww%0b wr%0b sk%0b, exp all 0",
               tag, valid_o, wr_w_o, wr_reg_o, skip_o);
    end
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    n_bad++;
    $display("FAIL R12 watchdog expired: got hang, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    bit [7:0] wpat [4] = '{8'h00, 8'h0F, 8'hA5, 8'hFF};
    bit [5:0] regops [12] = '{6'b011000, 6'b010010, 6'b010011, 6'b010100,
                               6'b011111, 6'b011001, 6'b011101, 6'b011010,
                               6'b011110, 6'b010101, 6'b010110, 6'b010111};
    bit [5:0] litops [4] = '{6'b111010, 6'b110100, 6'b110101, 6'b110110};
    repeat (3) @(negedge clk);
    check_idle("R12 reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R12 after reset");

    // R2 and R3: add/subtract sweeps across carry and half-carry boundaries
    for (int op = 0; op < 2; op++)
      for (int w = 0; w < 256; w += 3)
        for (int r = 0; r < 256; r++)
          apply({(op == 0) ? 6'b011011 : 6'b011100, r[0], 7'h15}, w[7:0], r[7:0], 3'(r + w));
    apply({6'b011100, 1'b0, 7'h01}, 8'h00, 8'h00, 3'b000); // R3 zero minus zero: C=1 HC=1 Z=1
    apply({6'b011011, 1'b1, 7'h7F}, 8'hFF, 8'h01, 3'b000); // R2 wrap to zero

    // R1 R4 R5 R6 R7: register ops over both destinations and varied flags
    for (int k = 0; k < 12; k++)
      for (int wi = 0; wi < 4; wi++)
        for (int r = 0; r < 256; r++)
          for (int t = 0; t < 2; t++)
            apply({regops[k], t[0], 7'(r ^ 8'h33)}, wpat[wi], r[7:0], 3'(r + k + t));

    // R8: every bit instruction, every index, every register value
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 8; b++)
        for (int r = 0; r < 256; r++)
          apply({2'b00, p[1:0], b[2:0], 7'(b * 9)}, 8'h5A, r[7:0], 3'(r));

    // R9: literal forms
    for (int k = 0; k < 4; k++)
      for (int wi = 0; wi < 4; wi++)
        for (int im = 0; im < 256; im++)
          apply({litops[k], im[7:0]}, wpat[wi], 8'h3C, 3'(im + wi));

    // R10: clear W, clear register, store W
    for (int f = 0; f < 8; f++) begin
      apply({6'b010000, 8'h80 | 8'(f)}, 8'h77, 8'h11, f[2:0]);
      apply({6'b010001, 1'b0, 7'(f + 3)}, 8'h77, 8'h11, f[2:0]);
      apply({6'b010001, 1'b1, 7'(f + 9)}, 8'(f * 37), 8'h11, f[2:0]);
    end

    // R11 and full prefix walk: every 6-bit opcode with a spread of low bytes
    for (int op = 0; op < 64; op++)
      for (int lo = 0; lo < 256; lo += 7)
        for (int f = 0; f < 8; f += 3)
          apply({op[5:0], lo[7:0]}, 8'(lo * 3), 8'(lo + op), f[2:0]);

    // R12: a bubble produces no write and no skip
    valid_i = 1'b0;
    instr_i = {6'b011010, 1'b1, 7'h05};
    reg_i = 8'hFF;
    @(negedge clk);
    check_idle("R12 bubble");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule